// File: doc/BRIEF.md
# Engine Reset Handshake Controller

This block sequences resets for a parameterized set of execution engines. Each engine has a small control register. Software uses it to ask the engine to drain, and the engine reports back through it when it is ready to be reset. The same register records a catastrophic error, which lets a reset go ahead without the drain handshake. Software changes these registers with masked writes: the upper half of the write word holds a per-bit enable for the lower half, so a single bit can be changed without a read-modify-write.

A separate domain register starts the resets. Writing a one to an engine's bit, or to the whole-device bit, drives that engine's reset output for a configurable number of cycles. The controller then waits for the engine to report idle, and then clears the bit. Software polls the bit until it reads zero and treats that as the completion acknowledgement. If a reset is forced onto an engine that had neither reported ready nor flagged a catastrophic error, a sticky flag records it. Each engine supplies an idle input and a catastrophic-error event input.

Top module: `rst_hs_ctrl`

## Requirements
- R1: After reset, every register reads zero and no engine reset output is driven.
- R2: Address j+1 selects the control register of engine j. Its fields are: bit 0 is the request, bit 1 is ready (read-only), bit 2 is the catastrophic error, and bit 3 is the forced flag. Bits 31:16 of a write enable bits 15:0 one for one, and a write changes no bit whose enable is clear.
- R3: Ready rises on the clock edge after one on which the request is set and the engine is idle. It stays low while the engine is not idle.
- R4: After the request is cleared, ready falls on the following clock edge.
- R5: A high cycle on the engine's catastrophic-error input sets bit 2. An enabled write of one to bit 2 clears it.
- R6: The domain register is at address 0. Bit 0 selects the whole device and bit j+1 selects engine j. Writing one starts a reset, writing zero has no effect, and a bit reads one while its reset is in progress.
- R7: Engine j's reset output goes high on the edge after its domain bit is set. It stays high for exactly PULSE_CYCLES cycles.
- R8: An engine's domain bit clears on the first edge after the pulse at which the engine is idle. The bit stays set while the engine is not idle.
- R9: If a reset starts while the engine has neither ready nor a catastrophic error, bit 3 is set. Bit 3 stays set until an enabled write of zero to bit 3. An enabled write of one to bit 3 has no effect.
- R10: A reset that starts while the catastrophic error is set does not set bit 3.
- R11: The whole-device bit resets every engine. It clears one edge after the last engine bit clears.
- R12: When an engine's reset completes, its request bit is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | AW | Register address: 0 is the domain register, j+1 is engine j |
| wdata_i | input | 32 | Write data; bits 31:16 are enables on control registers |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| eng_idle_i | input | N_ENG | Engine reports idle |
| eng_cat_i | input | N_ENG | Catastrophic-error event from the engine |
| eng_rst_o | output | N_ENG | Reset pulse to each engine |

## Verification
The checker assumes that after every pulse the engine's idle input eventually returns high. It also assumes that software writes only the addresses that exist. The bench holds idle low on one engine for a bounded window, then releases it, and writes only addresses 0 to N_ENG. The catastrophic-error input is raised for a single cycle at a time, outside any write to the same engine. This keeps the set-over-clear priority of that bit out of the checked cases.

// File: rtl/rst_hs_pkg.sv
package rst_hs_pkg;
  localparam int CTL_REQ  = 0;
  localparam int CTL_RDY  = 1;
  localparam int CTL_CAT  = 2;
  localparam int CTL_FRC  = 3;
  localparam int CTL_W    = 4;
  localparam int EN_SHIFT = 16;
  localparam int DOM_FULL = 0;

  typedef enum logic [1:0] {
    SEQ_IDLE    = 2'd0,
    SEQ_PULSE   = 2'd1,
    SEQ_RECOVER = 2'd2
  } seq_e;
endpackage

// File: rtl/rst_hs_lane.sv
module rst_hs_lane
  import rst_hs_pkg::*;
#(
  parameter int PULSE_CYCLES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_we_i,
  input  logic              req_val_i,
  input  logic              cat_ack_i,
  input  logic              frc_clr_i,
  input  logic              pending_i,
  input  logic              idle_i,
  input  logic              cat_i,
  output logic              rst_o,
  output logic              done_o,
  output logic [CTL_W-1:0]  ctl_o
);
  localparam int CW = (PULSE_CYCLES < 2) ? 1 : $clog2(PULSE_CYCLES);
  localparam logic [CW-1:0] CNT_LAST = CW'(PULSE_CYCLES - 1);

  seq_e          st_q;
  logic [CW-1:0] cnt_q;
  logic          req_q, rdy_q, cat_q, frc_q;
  logic          start;

  assign start  = pending_i && (st_q == SEQ_IDLE);
  assign done_o = (st_q == SEQ_RECOVER) && idle_i;
  assign rst_o  = (st_q == SEQ_PULSE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= SEQ_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        SEQ_IDLE: if (pending_i) begin
          st_q  <= SEQ_PULSE;
          cnt_q <= '0;
        end
        SEQ_PULSE: begin
          if (cnt_q == CNT_LAST) st_q <= SEQ_RECOVER;
          else cnt_q <= cnt_q + CW'(1);
        end
        SEQ_RECOVER: if (idle_i) st_q <= SEQ_IDLE;
        default: st_q <= SEQ_IDLE;
      endcase
    end
  end

  // handshake and status bits
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;
      rdy_q <= 1'b0;
      cat_q <= 1'b0;
      frc_q <= 1'b0;
    end else begin
      if (done_o)        req_q <= 1'b0;
      else if (req_we_i) req_q <= req_val_i;
      rdy_q <= req_q && idle_i;
      if (cat_i)          cat_q <= 1'b1;
      else if (cat_ack_i) cat_q <= 1'b0;
      if (start && !rdy_q && !cat_q) frc_q <= 1'b1;
      else if (frc_clr_i)            frc_q <= 1'b0;
    end
  end

  always_comb begin
    ctl_o          = '0;
    ctl_o[CTL_REQ] = req_q;
    ctl_o[CTL_RDY] = rdy_q;
    ctl_o[CTL_CAT] = cat_q;
    ctl_o[CTL_FRC] = frc_q;
  end
endmodule

// File: rtl/rst_hs_dom.sv
module rst_hs_dom #(
  parameter int N_ENG = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [N_ENG:0]   wsel_i,
  input  logic [N_ENG-1:0] done_i,
  output logic [N_ENG-1:0] dom_o,
  output logic             full_o
);
  logic [N_ENG-1:0] dom_q, set_eng;
  logic             full_q;

  assign set_eng = wr_i ? (wsel_i[N_ENG:1] | {N_ENG{wsel_i[0]}}) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dom_q  <= '0;
      full_q <= 1'b0;
    end else begin
      dom_q  <= set_eng | (dom_q & ~done_i);
      full_q <= (wr_i && wsel_i[0]) || (full_q && (|dom_q));
    end
  end

  assign dom_o  = dom_q;
  assign full_o = full_q;
endmodule

// File: rtl/rst_hs_ctrl.sv
module rst_hs_ctrl
  import rst_hs_pkg::*;
#(
  parameter int N_ENG        = 4,
  parameter int PULSE_CYCLES = 4,
  localparam int AW          = $clog2(N_ENG + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  input  logic [N_ENG-1:0] eng_idle_i,
  input  logic [N_ENG-1:0] eng_cat_i,
  output logic [N_ENG-1:0] eng_rst_o
);
  logic [N_ENG-1:0]        dom_busy;
  logic                    full_busy;
  logic [N_ENG-1:0]        done;
  logic [CTL_W-1:0]        ctl [N_ENG];
  logic                    dom_wr;
  logic                    unused_wdata;

  assign dom_wr       = wr_en_i && (addr_i == '0);
  assign unused_wdata = ^wdata_i;

  rst_hs_dom #(.N_ENG(N_ENG)) u_dom (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (dom_wr),
    .wsel_i (wdata_i[N_ENG:0]),
    .done_i (done),
    .dom_o  (dom_busy),
    .full_o (full_busy)
  );

  for (genvar j = 0; j < N_ENG; j++) begin : g_lane
    logic sel;
    assign sel = wr_en_i && (addr_i == AW'(j + 1));
    rst_hs_lane #(.PULSE_CYCLES(PULSE_CYCLES)) u_lane (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .req_we_i  (sel && wdata_i[EN_SHIFT + CTL_REQ]),
      .req_val_i (wdata_i[CTL_REQ]),
      .cat_ack_i (sel && wdata_i[EN_SHIFT + CTL_CAT] && wdata_i[CTL_CAT]),
      .frc_clr_i (sel && wdata_i[EN_SHIFT + CTL_FRC] && !wdata_i[CTL_FRC]),
      .pending_i (dom_busy[j]),
      .idle_i    (eng_idle_i[j]),
      .cat_i     (eng_cat_i[j]),
      .rst_o     (eng_rst_o[j]),
      .done_o    (done[j]),
      .ctl_o     (ctl[j])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == '0) begin
      rdata_o[N_ENG:1]    = dom_busy;
      rdata_o[DOM_FULL]   = full_busy;
    end
    for (int j = 0; j < N_ENG; j++) begin
      if (addr_i == AW'(j + 1)) rdata_o[CTL_W-1:0] = ctl[j];
    end
  end
endmodule

// File: rtl/rst_hs_chk.sv
module rst_hs_chk #(
  parameter int N_ENG = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_ENG-1:0] eng_rst_o,
  input logic [N_ENG-1:0] eng_idle_i,
  input logic [N_ENG-1:0] dom_busy,
  input logic             full_busy
);
  for (genvar j = 0; j < N_ENG; j++) begin : g_eng
    a_r7_pulse_while_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
      eng_rst_o[j] |-> dom_busy[j]);
    a_r7_pulse_after_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(eng_rst_o[j]) |-> $past(dom_busy[j]));
    a_r8_clear_after_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(dom_busy[j]) |-> ($past(eng_idle_i[j]) && !$past(eng_rst_o[j])));
  end

  a_r11_full_waits_engines: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(full_busy) |-> ($past(dom_busy) == '0));
endmodule

bind rst_hs_ctrl rst_hs_chk #(.N_ENG(N_ENG)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .eng_rst_o  (eng_rst_o),
  .eng_idle_i (eng_idle_i),
  .dom_busy   (dom_busy),
  .full_busy  (full_busy)
);

// File: tb/sim_rst_hs_ctrl.sv
module sim_rst_hs_ctrl;
  localparam int N  = 4;
  localparam int P  = 4;
  localparam int AW = $clog2(N + 1);

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_en_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [31:0]   wdata_i = '0;
  logic [31:0]   rdata_o;
  logic [N-1:0]  eng_idle_i = '1;
  logic [N-1:0]  eng_cat_i = '0;
  logic [N-1:0]  eng_rst_o;

  int checks = 0;
  int errors = 0;

  typedef struct {
    string       tag;
    logic [31:0] exp_rd;
    logic [N-1:0] exp_rst;
  } item_t;
  item_t sb[$];
  item_t cur;

  always #2 clk_i = ~clk_i;

  rst_hs_ctrl #(.N_ENG(N), .PULSE_CYCLES(P)) u0 (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .rdata_o,
    .eng_idle_i, .eng_cat_i, .eng_rst_o
  );

  // monitor: compare at the falling edge
  always @(negedge clk_i) begin
    if (sb.size() > 0) begin
      cur = sb.pop_front();
      checks += 2;
      if (rdata_o !== cur.exp_rd) begin
        errors++;
        $display("FAIL %s rdata got=%h exp=%h", cur.tag, rdata_o, cur.exp_rd);
      end
      if (eng_rst_o !== cur.exp_rst) begin
        errors++;
        $display("FAIL %s eng_rst got=%h exp=%h", cur.tag, eng_rst_o, cur.exp_rst);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(posedge clk_i); #1;
    wr_en_i = 1'b0; wdata_i = '0;
  endtask

  task automatic chk(input logic [AW-1:0] a, input logic [31:0] e_rd,
                     input logic [N-1:0] e_rst, input string tag);
    item_t it;
    addr_i = a;
    it.tag = tag; it.exp_rd = e_rd; it.exp_rst = e_rst;
    sb.push_back(it);
    @(negedge clk_i); #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    // R1 reset state
    for (int a = 0; a <= N; a++) chk(AW'(a), 32'h0, '0, "R1");

    // R2 masked write, R3 ready timing (engine 0)
    wr(1, 32'h0000_0001);         chk(1, 32'h0, '0, "R2 no enable");
    wr(1, 32'h0002_0002);         chk(1, 32'h0, '0, "R2 ready read-only");
    wr(1, 32'h0001_0001);         chk(1, 32'h1, '0, "R2 req set");
    tick(1);                      chk(1, 32'h3, '0, "R3 ready rises");

    // R3 idle low, R4 cancel (engine 3)
    eng_idle_i[3] = 1'b0;
    wr(4, 32'h0001_0001);
    tick(3);                      chk(4, 32'h1, '0, "R3 held by busy engine");
    eng_idle_i[3] = 1'b1;
    tick(1);                      chk(4, 32'h3, '0, "R3 ready after idle");
    wr(4, 32'h0001_0000);         chk(4, 32'h2, '0, "R4 req cleared");
    tick(1);                      chk(4, 32'h0, '0, "R4 ready dropped");

    // R5 catastrophic error, R10 bypass (engine 1)
    eng_cat_i[1] = 1'b1; tick(1); eng_cat_i[1] = 1'b0;
    chk(2, 32'h4, '0, "R5 cat set");
    wr(2, 32'h0000_0004);         chk(2, 32'h4, '0, "R2 cat no enable");
    wr(0, 32'h4);                 chk(0, 32'h4, '0, "R6 engine bit set");
    for (int i = 0; i < P; i++) begin
      tick(1);                    chk(0, 32'h4, 4'h2, "R7 pulse engine1");
    end
    tick(1);                      chk(0, 32'h4, '0, "R8 recover");
    tick(1);                      chk(2, 32'h4, '0, "R10 not forced");
    tick(1);                      chk(0, 32'h0, '0, "R8 bit cleared");
    wr(2, 32'h0004_0004);         chk(2, 32'h0, '0, "R5 cat acknowledged");

    // R7/R8/R12 with ready handshake (engine 0)
    wr(0, 32'h2);                 chk(0, 32'h2, '0, "R6 engine0 bit");
    for (int i = 0; i < P; i++) begin
      tick(1);                    chk(0, 32'h2, 4'h1, "R7 pulse engine0");
    end
    tick(1);                      chk(0, 32'h2, '0, "R7 pulse ended");
    tick(1);                      chk(1, 32'h2, '0, "R12 req cleared");
    tick(1);                      chk(1, 32'h0, '0, "R12 ready dropped, R9 not forced");
    tick(1);                      chk(0, 32'h0, '0, "R8 engine0 done");

    // R9 forced (engine 2)
    wr(0, 32'h8);                 chk(3, 32'h0, '0, "R9 before start");
    tick(1);                      chk(3, 32'h8, 4'h4, "R9 forced set");
    tick(P + 1);                  chk(3, 32'h8, '0, "R9 sticky");
    tick(1);                      chk(0, 32'h0, '0, "R8 engine2 done");
    wr(3, 32'h0008_0008);         chk(3, 32'h8, '0, "R9 write one ignored");
    wr(3, 32'h0008_0000);         chk(3, 32'h0, '0, "R9 cleared");

    // R8 waits for idle (engine 3)
    eng_idle_i[3] = 1'b0;
    wr(0, 32'h10);                chk(0, 32'h10, '0, "R6 engine3 bit");
    tick(P);                      chk(0, 32'h10, 4'h8, "R7 last pulse cycle");
    tick(1);                      chk(0, 32'h10, '0, "R8 waiting");
    tick(3);                      chk(0, 32'h10, '0, "R8 still waiting");
    eng_idle_i[3] = 1'b1;
    tick(1);                      chk(0, 32'h0, '0, "R8 clears on idle");

    // R11 full device
    wr(0, 32'h1);                 chk(0, 32'h1F, '0, "R11 all bits set");
    tick(1);                      chk(0, 32'h1F, 4'hF, "R11 all pulses");
    tick(P);                      chk(0, 32'h1F, '0, "R11 recover");
    tick(1);                      chk(0, 32'h1, '0, "R11 full lingers");
    tick(1);                      chk(0, 32'h0, '0, "R11 full cleared");
    chk(1, 32'h8, '0, "R9 full reset forced engine0");

    // R6 write of zero has no effect
    wr(0, 32'h0);                 chk(0, 32'h0, '0, "R6 zero write");
    tick(1);                      chk(0, 32'h0, '0, "R6 no pulse");

    tick(2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule